// File: doc/BRIEF.md
# Serial ADC Capture with Shared Sliding Scale

This block gathers the serial results of up to eight successive-approximation converters that are clocked together. Every converter sends its 16-bit answer most significant bit first, one bit per common bit strobe, while the conversion is still running. A channel starts when its start request is accepted; it then shifts in sixteen bits, drops the two lowest ones and subtracts the sliding-scale offset that was added to its analogue input. The difference saturates at zero. The corrected 14-bit word is then compared against that channel's own lower and upper window. It is presented with a one-cycle valid pulse, an in-window flag and an empty flag.

All channels share one sliding-scale counter. Each time at least one start is accepted, every accepted channel keeps the counter value of that moment, and the counter steps by one, wrapping at its top. The new value is then shifted serially to the external offset DAC, followed by a load strobe. No new conversion may start until that update is finished. The handshake signal `conv_ok_o` tells the surrounding control logic when a start can be taken. After reset the counter is zero, and the external DAC is assumed to hold zero as well.

A small register port holds the per-channel windows. Each window reads back exactly the value last written to it.

Top module: `sscale_adc_capture`

## Requirements
- R1: After reset the counter is 0, `conv_ok_o` is 1, no valid, shift or load strobe is active, every lower window reads 0 and every upper window reads 16'h3FFF (all ones in 14 bits).
- R2: A started channel samples `adc_sdata_i[ch]` on each cycle with `bit_stb_i` high, first bit = bit 15; its result is bits 15..2 of the 16 collected bits minus the offset latched at its start.
- R3: An accepted start makes each accepted channel latch the counter value of that cycle; the counter then increments by one per cycle with any accepted start (not per channel) and wraps from 255 to 0.
- R4: In the cycle after an accepted start, the DAC update begins: 8 cycles with `dac_shift_o` high carrying the new counter value on `dac_bit_o`, MSB first, then one cycle of `dac_load_o`; `conv_ok_o` is 0 from the first shift cycle through the load cycle.
- R5: A start request made while `conv_ok_o` is 0, or made to a channel that is still converting, is ignored: it starts nothing, latches nothing and does not move the counter.
- R6: If the latched offset exceeds the 14-bit value, the corrected result is 0.
- R7: `res_empty_o[ch]` is 1 exactly when the corrected result is 0.
- R8: `res_inwin_o[ch]` is 1 exactly when lower <= result <= upper, with both bounds inclusive.
- R9: A write with address bit 0 = 0 sets the lower and with bit 0 = 1 the upper window of channel `addr[3:1]`; reading the same address returns the written 14-bit value.
- R10: `res_valid_o[ch]` is high for exactly the one cycle after the clock edge that takes the 16th bit; the result data and flags hold until that channel's next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_go_i | input | 8 | Per-channel conversion start request |
| conv_ok_o | output | 1 | High when a start can be accepted |
| bit_stb_i | input | 1 | Common strobe: one serial bit per high cycle |
| adc_sdata_i | input | 8 | Serial data, one line per converter |
| dac_bit_o | output | 1 | Serial offset bit to the DAC |
| dac_shift_o | output | 1 | High while `dac_bit_o` carries a bit |
| dac_load_o | output | 1 | One-cycle load strobe after the last bit |
| cfg_wr_en_i | input | 1 | Window register write enable |
| cfg_wr_addr_i | input | 4 | Write address {channel, upper/lower} |
| cfg_wr_data_i | input | 14 | Write data |
| cfg_rd_addr_i | input | 4 | Read address {channel, upper/lower} |
| cfg_rd_data_o | output | 14 | Read data |
| res_valid_o | output | 8 | Per-channel result valid pulse |
| res_data_o | output | 112 | Corrected results, channel n at bits 14n+13..14n |
| res_inwin_o | output | 8 | Result is inside its window |
| res_empty_o | output | 8 | Corrected result is zero |

## Verification
Random 16-bit streams are run against random start masks. This separates channel-to-channel routing and the MSB-first order, and it checks that each channel subtracts its own latched offset and not the live counter. Directed values place the 14-bit value just below, equal to and above the offset, and the result exactly on each window bound. These cases separate saturation from wraparound and inclusive bounds from exclusive ones. Start requests aimed at busy channels and requests made during a DAC update are then followed by a check of the next serialized counter value, so a wrongly accepted start shows up as a skipped step. More than 256 rounds carry the counter past its wrap.

// File: rtl/sscale_pkg.sv
// Shared types for the sliding-scale ADC capture block.
package sscale_pkg;

    // State of the serial offset DAC updater.
    typedef enum logic [1:0] {
        DAC_IDLE  = 2'd0,
        DAC_SHIFT = 2'd1,
        DAC_LOAD  = 2'd2
    } dac_state_t;

endpackage

// File: rtl/sscale_ctrl.sv
// Shared sliding-scale counter and serial DAC updater.
// Assumes: start_any_i is only raised while ready_o is high.
// Each accepted start advances the counter by one (modulo 2**SS_W). The new
// value is shifted out MSB first, one bit per cycle, and a load strobe follows.
module sscale_ctrl
    import sscale_pkg::*;
#(
    parameter int SS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_any_i,
    output logic [SS_W-1:0] cnt_o,
    output logic            ready_o,
    output logic            dac_bit_o,
    output logic            dac_shift_o,
    output logic            dac_load_o
);
    localparam int BC_W = $clog2(SS_W + 1);

    dac_state_t      state;
    logic [SS_W-1:0] cnt;
    logic [SS_W-1:0] sh;
    logic [BC_W-1:0] left;

    // Counter step, shift register and DAC update sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DAC_IDLE;
            cnt   <= '0;
            sh    <= '0;
            left  <= '0;
        end else begin
            case (state)
                DAC_IDLE: begin
                    if (start_any_i) begin
                        cnt   <= cnt + SS_W'(1);
                        sh    <= cnt + SS_W'(1);
                        left  <= BC_W'(SS_W);
                        state <= DAC_SHIFT;
                    end
                end
                DAC_SHIFT: begin
                    sh   <= sh << 1;
                    left <= left - BC_W'(1);
                    if (left == BC_W'(1)) begin
                        state <= DAC_LOAD;
                    end
                end
                DAC_LOAD: state <= DAC_IDLE;
                default:  state <= DAC_IDLE;
            endcase
        end
    end

    // Output decode from the sequencer state.
    always_comb begin
        ready_o     = (state == DAC_IDLE);
        dac_shift_o = (state == DAC_SHIFT);
        dac_load_o  = (state == DAC_LOAD);
        dac_bit_o   = dac_shift_o & sh[SS_W-1];
        cnt_o       = cnt;
    end

endmodule

// File: rtl/sscale_winregs.sv
// Per-channel lower/upper acceptance window registers with readback.
// Address layout: bit 0 selects lower (0) or upper (1); the bits above it
// give the channel. Assumes NUM_CH >= 2.
module sscale_winregs #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 14,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [NUM_CH*DATA_W-1:0]   lo_o,
    output logic [NUM_CH*DATA_W-1:0]   hi_o
);
    logic [DATA_W-1:0] lo_q [NUM_CH];
    logic [DATA_W-1:0] hi_q [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_win
        // Window register pair of one channel: open window after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[i] <= '0;
                hi_q[i] <= '1;
            end else if (wr_en_i && (wr_addr_i[ADDR_W-1:1] == CH_W'(i))) begin
                if (wr_addr_i[0]) hi_q[i] <= wr_data_i;
                else              lo_q[i] <= wr_data_i;
            end
        end
        assign lo_o[i*DATA_W +: DATA_W] = lo_q[i];
        assign hi_o[i*DATA_W +: DATA_W] = hi_q[i];
    end

    // Readback multiplexer.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr_i[ADDR_W-1:1] == CH_W'(i)) begin
                rd_data_o = rd_addr_i[0] ? hi_q[i] : lo_q[i];
            end
        end
    end

endmodule

// File: rtl/sscale_chan.sv
// One converter channel: serial-to-parallel capture, offset removal,
// window test. Assumes start_i is only raised while busy_o is low, and
// SS_W <= RAW_W - DROP. The bit in flight on the 16th strobe is used
// directly, so the result is registered on that same edge.
module sscale_chan #(
    parameter int RAW_W = 16,
    parameter int DROP  = 2,
    parameter int SS_W  = 8,
    localparam int DATA_W = RAW_W - DROP,
    localparam int BIT_W  = $clog2(RAW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SS_W-1:0]   scale_i,
    input  logic              bit_stb_i,
    input  logic              sdata_i,
    input  logic [DATA_W-1:0] win_lo_i,
    input  logic [DATA_W-1:0] win_hi_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              inwin_o,
    output logic              empty_o
);
    logic              busy;
    logic [BIT_W-1:0]  bitcnt;
    logic [RAW_W-2:0]  sr;
    logic [SS_W-1:0]   ss_lat;

    logic [RAW_W-1:0]  raw_full;
    logic [DATA_W-1:0] raw_trim;
    logic [DATA_W-1:0] scale_ext;
    logic [DATA_W-1:0] corr;
    logic              last;

    // Assemble the full word, trim, subtract with saturation at zero.
    always_comb begin
        raw_full  = {sr, sdata_i};
        raw_trim  = raw_full[RAW_W-1:DROP];
        scale_ext = DATA_W'(ss_lat);
        corr      = (raw_trim >= scale_ext) ? (raw_trim - scale_ext) : '0;
        last      = busy && bit_stb_i && (bitcnt == BIT_W'(RAW_W - 1));
    end

    // Conversion tracking: start, bit collection, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            bitcnt <= '0;
            sr     <= '0;
            ss_lat <= '0;
        end else if (start_i && !busy) begin
            busy   <= 1'b1;
            bitcnt <= '0;
            ss_lat <= scale_i;
        end else if (busy && bit_stb_i) begin
            sr     <= {sr[RAW_W-3:0], sdata_i};
            bitcnt <= bitcnt + BIT_W'(1);
            if (last) busy <= 1'b0;
        end
    end

    // Result register: pulse valid, hold data and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            inwin_o <= 1'b0;
            empty_o <= 1'b0;
        end else begin
            valid_o <= last;
            if (last) begin
                data_o  <= corr;
                inwin_o <= (corr >= win_lo_i) && (corr <= win_hi_i);
                empty_o <= (corr == '0);
            end
        end
    end

    assign busy_o = busy;

endmodule

// File: rtl/sscale_adc_capture.sv
// Top: eight serial converter channels sharing one sliding-scale counter.
// Assumes all converters share one bit strobe; the external DAC holds 0
// after reset. A start is accepted only while the DAC updater is idle and
// the addressed channel is not converting.
module sscale_adc_capture #(
    parameter int NUM_CH = 8,
    parameter int RAW_W  = 16,
    parameter int DROP   = 2,
    parameter int SS_W   = 8,
    localparam int DATA_W = RAW_W - DROP,
    localparam int ADDR_W = $clog2(NUM_CH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        conv_go_i,
    output logic                     conv_ok_o,
    input  logic                     bit_stb_i,
    input  logic [NUM_CH-1:0]        adc_sdata_i,
    output logic                     dac_bit_o,
    output logic                     dac_shift_o,
    output logic                     dac_load_o,
    input  logic                     cfg_wr_en_i,
    input  logic [ADDR_W-1:0]        cfg_wr_addr_i,
    input  logic [DATA_W-1:0]        cfg_wr_data_i,
    input  logic [ADDR_W-1:0]        cfg_rd_addr_i,
    output logic [DATA_W-1:0]        cfg_rd_data_o,
    output logic [NUM_CH-1:0]        res_valid_o,
    output logic [NUM_CH*DATA_W-1:0] res_data_o,
    output logic [NUM_CH-1:0]        res_inwin_o,
    output logic [NUM_CH-1:0]        res_empty_o
);
    logic [NUM_CH-1:0]        chan_busy;
    logic [NUM_CH-1:0]        start_acc;
    logic                     accept_any;
    logic [SS_W-1:0]          scale_cnt;
    logic [NUM_CH*DATA_W-1:0] win_lo;
    logic [NUM_CH*DATA_W-1:0] win_hi;

    // Start acceptance: DAC idle and channel free.
    always_comb begin
        start_acc  = conv_go_i & ~chan_busy & {NUM_CH{conv_ok_o}};
        accept_any = |start_acc;
    end

    sscale_ctrl #(.SS_W(SS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_any_i (accept_any),
        .cnt_o       (scale_cnt),
        .ready_o     (conv_ok_o),
        .dac_bit_o   (dac_bit_o),
        .dac_shift_o (dac_shift_o),
        .dac_load_o  (dac_load_o)
    );

    sscale_winregs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en_i),
        .wr_addr_i (cfg_wr_addr_i),
        .wr_data_i (cfg_wr_data_i),
        .rd_addr_i (cfg_rd_addr_i),
        .rd_data_o (cfg_rd_data_o),
        .lo_o      (win_lo),
        .hi_o      (win_hi)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sscale_chan #(.RAW_W(RAW_W), .DROP(DROP), .SS_W(SS_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_acc[i]),
            .scale_i   (scale_cnt),
            .bit_stb_i (bit_stb_i),
            .sdata_i   (adc_sdata_i[i]),
            .win_lo_i  (win_lo[i*DATA_W +: DATA_W]),
            .win_hi_i  (win_hi[i*DATA_W +: DATA_W]),
            .busy_o    (chan_busy[i]),
            .valid_o   (res_valid_o[i]),
            .data_o    (res_data_o[i*DATA_W +: DATA_W]),
            .inwin_o   (res_inwin_o[i]),
            .empty_o   (res_empty_o[i])
        );
    end

endmodule

// File: rtl/sscale_adc_capture_chk.sv
// Property checker for sscale_adc_capture, attached with bind below.
module sscale_adc_capture_chk #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 14,
    parameter int SS_W   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     conv_ok_o,
    input logic                     dac_shift_o,
    input logic                     dac_load_o,
    input logic [NUM_CH-1:0]        res_valid_o,
    input logic [NUM_CH*DATA_W-1:0] res_data_o,
    input logic [NUM_CH-1:0]        res_empty_o,
    input logic [SS_W-1:0]          scale_cnt,
    input logic                     accept_any
);
    // R3: one step per accepted start cycle
    a_r3_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept_any |=> (scale_cnt == $past(scale_cnt) + SS_W'(1)));

    // R5: no counter movement while starts are blocked
    a_r5_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_ok_o |=> $stable(scale_cnt));

    // R4: shifting blocks new conversions
    a_r4_shift_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        dac_shift_o |-> !conv_ok_o);

    // R4: load lasts one cycle and reopens starts
    a_r4_load_once: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load_o |=> (!dac_load_o && conv_ok_o));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R10: valid is a single-cycle pulse
        a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid_o[i] |=> !res_valid_o[i]);

        // R7: empty flag matches a zero result
        a_r7_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid_o[i] |-> (res_empty_o[i] == (res_data_o[i*DATA_W +: DATA_W] == '0)));
    end

endmodule

bind sscale_adc_capture sscale_adc_capture_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .SS_W   (SS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_ok_o   (conv_ok_o),
    .dac_shift_o (dac_shift_o),
    .dac_load_o  (dac_load_o),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o),
    .res_empty_o (res_empty_o),
    .scale_cnt   (scale_cnt),
    .accept_any  (accept_any)
);

// File: tb/sscale_adc_capture_bench.sv
// Self-checking bench: directed corners plus seeded random rounds.
module sscale_adc_capture_bench;
    localparam int NUM_CH = 8;
    localparam int RAW_W  = 16;
    localparam int DATA_W = 14;
    localparam int SS_W   = 8;
    localparam int ADDR_W = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_CH-1:0]        conv_go = '0;
    logic                     conv_ok;
    logic                     bit_stb = 1'b0;
    logic [NUM_CH-1:0]        sdata = '0;
    logic                     dac_bit, dac_shift, dac_load;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        wr_addr = '0;
    logic [DATA_W-1:0]        wr_data = '0;
    logic [ADDR_W-1:0]        rd_addr = '0;
    logic [DATA_W-1:0]        rd_data;
    logic [NUM_CH-1:0]        res_valid, res_inwin, res_empty;
    logic [NUM_CH*DATA_W-1:0] res_data;

    int n_tests = 0;
    int n_fail  = 0;
    int m_cnt   = 0;
    logic [15:0] raw_v [NUM_CH];
    int          ss_v  [NUM_CH];
    int          win_lo[NUM_CH];
    int          win_hi[NUM_CH];

    always #5 clk = ~clk;

    sscale_adc_capture u_sscale_adc_capture (
        .clk(clk), .rst_n(rst_n), .conv_go_i(conv_go), .conv_ok_o(conv_ok),
        .bit_stb_i(bit_stb), .adc_sdata_i(sdata), .dac_bit_o(dac_bit),
        .dac_shift_o(dac_shift), .dac_load_o(dac_load),
        .cfg_wr_en_i(wr_en), .cfg_wr_addr_i(wr_addr), .cfg_wr_data_i(wr_data),
        .cfg_rd_addr_i(rd_addr), .cfg_rd_data_o(rd_data),
        .res_valid_o(res_valid), .res_data_o(res_data),
        .res_inwin_o(res_inwin), .res_empty_o(res_empty)
    );

    task automatic chk(input string req, input string what, input int act, input int exp_v);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    function automatic int exp_corr(input logic [15:0] raw, input int ss);
        int r14 = int'(raw[15:2]);
        return (r14 >= ss) ? r14 - ss : 0;
    endfunction

    task automatic wr_win(input int ch, input bit hi, input int val);
        wr_en = 1'b1; wr_addr = ADDR_W'({ch[2:0], hi}); wr_data = DATA_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (hi) win_hi[ch] = val; else win_lo[ch] = val;
        rd_addr = ADDR_W'({ch[2:0], hi});
        #1;
        chk("R9", "window readback", int'(rd_data), val);
    endtask

    // Start a conversion set, check the DAC update and a blocked start.
    task automatic start_conv(input logic [NUM_CH-1:0] mask, input logic [NUM_CH-1:0] blocked);
        int nv;
        chk("R4", "conv_ok before start", int'(conv_ok), 1);
        conv_go = mask;
        @(negedge clk);
        conv_go = '0;
        for (int c = 0; c < NUM_CH; c++) if (mask[c]) ss_v[c] = m_cnt;
        m_cnt = (m_cnt + 1) % 256;
        nv = m_cnt;
        chk("R4", "conv_ok low during update", int'(conv_ok), 0);
        for (int k = 0; k < SS_W; k++) begin
            chk("R4", "dac_shift", int'(dac_shift), 1);
            chk(nv == 0 ? "R3 wrap" : "R3", "dac serial bit", int'(dac_bit), (nv >> (SS_W - 1 - k)) & 1);
            conv_go = (k == 1) ? blocked : '0;
            @(negedge clk);
        end
        conv_go = '0;
        chk("R4", "dac_load", int'(dac_load), 1);
        chk("R4", "shift ended", int'(dac_shift), 0);
        @(negedge clk);
        chk("R4", "conv_ok back", int'(conv_ok), 1);
    endtask

    // Stream 16 bits per channel; poke busy channels midway; check results.
    task automatic stream(input logic [NUM_CH-1:0] mask, input logic [NUM_CH-1:0] busy_go);
        logic [DATA_W-1:0] held [NUM_CH];
        for (int b = RAW_W - 1; b >= 0; b--) begin
            bit_stb = 1'b1;
            for (int c = 0; c < NUM_CH; c++) sdata[c] = raw_v[c][b];
            conv_go = (b == 8) ? busy_go : '0;
            @(negedge clk);
        end
        bit_stb = 1'b0; conv_go = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            int e = exp_corr(raw_v[c], ss_v[c]);
            chk(mask[c] ? "R10" : "R5", "valid pulse", int'(res_valid[c]), int'(mask[c]));
            if (mask[c]) begin
                chk(raw_v[c][15:2] < ss_v[c] ? "R6" : "R2", "corrected data",
                    int'(res_data[c*DATA_W +: DATA_W]), e);
                chk("R7", "empty flag", int'(res_empty[c]), int'(e == 0));
                chk("R8", "in-window flag", int'(res_inwin[c]),
                    int'(e >= win_lo[c] && e <= win_hi[c]));
            end
            held[c] = res_data[c*DATA_W +: DATA_W];
        end
        @(negedge clk);
        chk("R10", "valid low after pulse", int'(res_valid), 0);
        for (int c = 0; c < NUM_CH; c++)
            chk("R10", "data held", int'(res_data[c*DATA_W +: DATA_W]), int'(held[c]));
        // A busy-channel start must not have started anything.
        chk("R5", "no channel restarted", int'(conv_ok), 1);
    endtask

    task automatic finish_up;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd24681));
        for (int c = 0; c < NUM_CH; c++) begin
            win_lo[c] = 0; win_hi[c] = 16'h3FFF; ss_v[c] = 0; raw_v[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "conv_ok", int'(conv_ok), 1);
        chk("R1", "valid", int'(res_valid), 0);
        chk("R1", "dac strobes", int'({dac_shift, dac_load}), 0);
        rd_addr = 4'b0000; #1;
        chk("R1", "lower window reset", int'(rd_data), 0);
        rd_addr = 4'b1111; #1;
        chk("R1", "upper window reset", int'(rd_data), 16'h3FFF);

        // Directed round 1: offset 0, exact bounds and an empty result.
        wr_win(0, 0, 16'h10); wr_win(0, 1, 16'h20);
        wr_win(1, 0, 16'h10); wr_win(1, 1, 16'h20);
        wr_win(2, 0, 16'h10); wr_win(2, 1, 16'h20);
        raw_v[0] = 16'h0010 << 2 | 16'h3;
        raw_v[1] = 16'h0020 << 2;
        raw_v[2] = 16'h0021 << 2 | 16'h1;
        raw_v[3] = 16'h0002;
        start_conv(8'h0F, 8'hF0);
        stream(8'h0F, 8'h05);

        // Directed round 2: offset 1, saturation and top value.
        wr_win(7, 0, 16'h10);
        raw_v[4] = 16'h0000;
        raw_v[5] = 16'h0004;
        raw_v[6] = 16'hFFFF;
        raw_v[7] = 16'h000F << 2;
        start_conv(8'hF0, 8'h0F);
        stream(8'hF0, 8'h30);

        // Random rounds, enough to carry the counter past its wrap.
        for (int r = 0; r < 270; r++) begin
            logic [NUM_CH-1:0] mask;
            if (($urandom % 4) == 0) begin
                int ch = $urandom % NUM_CH;
                int lo = $urandom_range(0, 16'h1FFF);
                wr_win(ch, 0, lo);
                wr_win(ch, 1, lo + $urandom_range(0, 16'h1FFF));
            end
            mask = NUM_CH'($urandom);
            if (mask == '0) mask = 8'h01;
            for (int c = 0; c < NUM_CH; c++) begin
                case ($urandom % 4)
                    0: raw_v[c] = 16'((m_cnt + ($urandom % 3)) << 2 | ($urandom % 4));
                    1: raw_v[c] = 16'(($urandom % (m_cnt + 1)) << 2);
                    default: raw_v[c] = 16'($urandom);
                endcase
            end
            start_conv(mask, NUM_CH'($urandom) & ~mask);
            stream(mask, NUM_CH'($urandom) & mask);
        end
        finish_up();
    end

endmodule